// File: doc/BRIEF.md
# Double-Register Funnel Extract Unit

This block runs one instruction: extract a word from a pair of registers. It reads two 32-bit data registers from a local 16-entry register file and joins them into a 64-bit value. The first source gives the high half and the second source gives the low half, and both fields may name the same register. The block shifts that value left and writes the upper 32 bits of the shifted value back to a destination register. The shift amount comes from one of two places: a 5-bit immediate in the instruction, or the low five bits of a third register that the instruction names. Each of the two encodings has its own primary and secondary opcode. An instruction whose opcode fields match neither encoding raises an illegal flag, and nothing is written.

The caller presents the instruction with a valid strobe, and the result lands in the register file at the next rising clock edge. Sources are read before that edge, so the destination may also be a source. The block has no condition or overflow flags and changes none. A separate debug port can preload any register and read any register back combinationally. A checker uses it to compare the file against a model of the 64-bit shift.

Top module: `dx_extract_unit`

## Requirements
- R1: A synchronous active-low reset (rst_n low at a rising edge) clears all 16 registers, done_o and illegal_o to zero.
- R2: Immediate format: instr[7:0]=0x77 and instr[22:21]=0. The shift amount is instr[27:23], the destination is instr[31:28], the low source is instr[15:12] and the high source is instr[11:8]. At the next rising edge the destination receives bits 63:32 of ({high,low} << amount).
- R3: Register format: instr[7:0]=0x17 and instr[23:21]=4. The destination and sources sit at the same positions as in R2. instr[27:24] names a register whose bits 4:0 give the amount, and its bits 31:5 have no effect on the result.
- R4: When the high and low source fields name the same register, the result is that register rotated left by the amount.
- R5: A shift amount of 0 writes the high source register unchanged.
- R6: instr[20:16] has no effect on the result in either format.
- R7: An instruction with instr_valid high that matches neither R2 nor R3 sets illegal_o high for exactly the next cycle, leaves done_o low, and writes no register.
- R8: done_o is high for exactly the cycle after each accepted legal instruction. Both done_o and illegal_o are low after any cycle with instr_valid low.
- R9: dbg_we high at a rising edge writes dbg_wdata to register dbg_waddr. If an instruction writes the same index in the same cycle, the instruction result is kept. Writes to different indices both take effect.
- R10: dbg_rdata always shows the current contents of register dbg_raddr, with no clock delay.
- R11: Sources are read before the write of the same cycle, so a destination equal to a source uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| dbg_we | input | 1 | Debug write enable |
| dbg_waddr | input | 4 | Debug write index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_raddr | input | 4 | Debug read index |
| dbg_rdata | output | 32 | Debug read data (combinational) |
| done_o | output | 1 | Pulses the cycle after a legal write |
| illegal_o | output | 1 | Pulses the cycle after an unrecognised encoding |

## Verification
The shift is tried with immediate amounts of 0, 1, 11 and 31, which separate the pass-through case, a single step, a mixed multi-stage amount and the full-width case. Register-format instructions use amount registers with their upper bits set, which exposes any decode that looks past bit 4. Runs with the same register in both source fields and runs where the destination is also a source test whether the unit treats the pair as a true 64-bit concatenation and reads before it writes. Encodings that break one opcode field at a time, junk in bits 20:16, and a debug write that collides with a writeback test the decode and the write priority.

// File: rtl/dx_pkg.sv
// Shared constants and types for the funnel extract unit.
// Assumes a 32-bit data word and a 16-entry register file.
package dx_pkg;
    localparam int XLEN    = 32;
    localparam int NREG    = 16;
    localparam int AW      = $clog2(NREG);
    localparam int SHW     = $clog2(XLEN);
    localparam int ILEN    = 32;

    localparam logic [7:0] OPC_IMM = 8'h77;
    localparam logic [7:0] OPC_REG = 8'h17;
    localparam logic [1:0] SUB_IMM = 2'd0;
    localparam logic [2:0] SUB_REG = 3'd4;

    typedef enum logic [1:0] {
        FMT_BAD = 2'd0,
        FMT_IMM = 2'd1,
        FMT_REG = 2'd2
    } dx_fmt_e;

    typedef struct packed {
        dx_fmt_e             fmt;
        logic [AW-1:0]       dst;
        logic [AW-1:0]       src_hi;
        logic [AW-1:0]       src_lo;
        logic [AW-1:0]       src_amt;
        logic [SHW-1:0]      imm_amt;
    } dx_op_t;
endpackage

// File: rtl/dx_decode.sv
// Field decoder: sorts the instruction word into one of two formats or
// marks it illegal, and pulls out the register indices and the immediate.
// Assumes the bit layout of dx_pkg. Bits 20:16 are deliberately unused.
module dx_decode
    import dx_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output dx_op_t          op
);
    logic is_imm;
    logic is_reg;
    logic unused_dontcare;

    // Match each format on its primary and secondary opcode fields.
    always_comb begin
        is_imm = (instr[7:0] == OPC_IMM) && (instr[22:21] == SUB_IMM);
        is_reg = (instr[7:0] == OPC_REG) && (instr[23:21] == SUB_REG);
    end

    // Assemble the decoded operation.
    always_comb begin
        op.fmt     = is_imm ? FMT_IMM : (is_reg ? FMT_REG : FMT_BAD);
        op.dst     = instr[31:28];
        op.src_lo  = instr[15:12];
        op.src_hi  = instr[11:8];
        op.src_amt = instr[27:24];
        op.imm_amt = instr[27:23];
    end

    assign unused_dontcare = ^instr[20:16];
endmodule

// File: rtl/dx_regfile.sv
// Register file with NRD combinational read ports and two write ports.
// Write port A (instruction writeback) wins over port B (debug) on the
// same index. Assumes a synchronous active-low reset clears every entry.
module dx_regfile #(
    parameter int W   = 32,
    parameter int N   = 16,
    parameter int NRD = 4,
    localparam int AW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata,
    input  logic                   a_we,
    input  logic [AW-1:0]          a_addr,
    input  logic [W-1:0]           a_data,
    input  logic                   b_we,
    input  logic [AW-1:0]          b_addr,
    input  logic [W-1:0]           b_data
);
    logic [W-1:0] mem [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        // Update one entry: reset, then writeback, then debug.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (a_we && (a_addr == AW'(i))) begin
                mem[i] <= a_data;
            end else if (b_we && (b_addr == AW'(i))) begin
                mem[i] <= b_data;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Combinational read of one port.
        always_comb rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/dx_funnel.sv
// Funnel shifter: shifts {hi,lo} left by amt and returns the upper word.
// Built as a logarithmic stack of SHW conditional shift stages.
// Assumes amt is already limited to SHW bits.
module dx_funnel #(
    parameter int W    = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   hi,
    input  logic [W-1:0]   lo,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   res
);
    logic [2*W-1:0] stg [SHW+1];

    assign stg[0] = {hi, lo};

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        // Stage k shifts by 2**k when amt bit k is set.
        always_comb stg[k+1] = amt[k] ? (stg[k] << (2**k)) : stg[k];
    end

    assign res = stg[SHW][2*W-1:W];
endmodule

// File: rtl/dx_extract_unit.sv
// Top of the double-register extract unit: decode, register reads, shift
// amount selection, funnel shift, writeback and the one-cycle status pulses.
// Assumes one instruction per valid cycle and no pipelining.
module dx_extract_unit
    import dx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [ILEN-1:0] instr,
    input  logic            dbg_we,
    input  logic [AW-1:0]   dbg_waddr,
    input  logic [XLEN-1:0] dbg_wdata,
    input  logic [AW-1:0]   dbg_raddr,
    output logic [XLEN-1:0] dbg_rdata,
    output logic            done_o,
    output logic            illegal_o
);
    localparam int NRD = 4;

    dx_op_t                     op;
    logic [NRD-1:0][AW-1:0]     rd_addr;
    logic [NRD-1:0][XLEN-1:0]   rd_data;
    logic [XLEN-1:0]            hi_word;
    logic [XLEN-1:0]            lo_word;
    logic [XLEN-1:0]            amt_word;
    logic [SHW-1:0]             sh_amt;
    logic [XLEN-1:0]            res_word;
    logic                       wb_en;
    logic                       bad_op;
    logic [XLEN-SHW-1:0]        unused_amt_hi;

    dx_decode u_dec (
        .instr (instr),
        .op    (op)
    );

    // Route the read addresses: high, low, amount, debug.
    always_comb begin
        rd_addr[0] = op.src_hi;
        rd_addr[1] = op.src_lo;
        rd_addr[2] = op.src_amt;
        rd_addr[3] = dbg_raddr;
    end

    dx_regfile #(.W(XLEN), .N(NREG), .NRD(NRD)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .raddr  (rd_addr),
        .rdata  (rd_data),
        .a_we   (wb_en),
        .a_addr (op.dst),
        .a_data (res_word),
        .b_we   (dbg_we),
        .b_addr (dbg_waddr),
        .b_data (dbg_wdata)
    );

    // Split read data and pick the shift amount by format.
    always_comb begin
        hi_word   = rd_data[0];
        lo_word   = rd_data[1];
        amt_word  = rd_data[2];
        dbg_rdata = rd_data[3];
        sh_amt    = (op.fmt == FMT_REG) ? amt_word[SHW-1:0] : op.imm_amt;
    end

    assign unused_amt_hi = amt_word[XLEN-1:SHW];

    dx_funnel #(.W(XLEN)) u_fun (
        .hi  (hi_word),
        .lo  (lo_word),
        .amt (sh_amt),
        .res (res_word)
    );

    // Qualify writeback and the illegal case with the valid strobe.
    always_comb begin
        wb_en  = instr_valid && (op.fmt != FMT_BAD);
        bad_op = instr_valid && (op.fmt == FMT_BAD);
    end

    // Register the one-cycle completion and illegal pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            done_o    <= wb_en;
            illegal_o <= bad_op;
        end
    end
endmodule

// File: rtl/dx_extract_chk.sv
// Property checker for dx_extract_unit, attached by bind below.
// Decodes the opcode fields on its own from the instruction port.
module dx_extract_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [31:0] instr,
    input logic        done_o,
    input logic        illegal_o,
    input logic        wb_en,
    input logic [4:0]  sh_amt,
    input logic [31:0] hi_word,
    input logic [31:0] res_word
);
    logic legal;
    // Independent opcode match used by the properties.
    always_comb legal = (instr[7:0] == 8'h77 && instr[22:21] == 2'b00)
                     || (instr[7:0] == 8'h17 && instr[23:21] == 3'b100);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!done_o && !illegal_o));
    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && illegal_o));
    // R7
    illegal_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !legal) |=> illegal_o);
    // R8
    done_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && legal) |=> done_o);
    // R8
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!done_o && !illegal_o));
    // R5
    zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && sh_amt == 5'd0) |-> (res_word == hi_word));
endmodule

bind dx_extract_unit dx_extract_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .done_o      (done_o),
    .illegal_o   (illegal_o),
    .wb_en       (wb_en),
    .sh_amt      (sh_amt),
    .hi_word     (hi_word),
    .res_word    (res_word)
);

// File: tb/sim_dx_extract_unit.sv
// Scoreboard bench: the driver predicts each result from a register model
// and queues it; the monitor pops on every status pulse and compares.
module sim_dx_extract_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        dbg_we = 1'b0;
    logic [3:0]  dbg_waddr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [3:0]  dbg_raddr = '0;
    logic [31:0] dbg_rdata;
    logic        done_o;
    logic        illegal_o;

    int errors = 0;
    int checks = 0;
    logic [31:0] mdl [16];

    typedef struct {
        bit          ill;
        logic [3:0]  dst;
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    dx_extract_unit u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_x(logic [31:0] hi, logic [31:0] lo, int amt);
        logic [63:0] t;
        t = {hi, lo} << amt;
        return t[63:32];
    endfunction

    function automatic logic [31:0] enc_imm(int d, int lo, int hi, int amt, int junk);
        return {4'(d), 5'(amt), 2'b00, 5'(junk), 4'(lo), 4'(hi), 8'h77};
    endfunction

    function automatic logic [31:0] enc_reg(int d, int lo, int hi, int s, int junk);
        return {4'(d), 4'(s), 3'b100, 5'(junk), 4'(lo), 4'(hi), 8'h17};
    endfunction

    // Driver: predict, queue, present for one cycle; optional debug write.
    task automatic issue(input logic [31:0] ins, input string tag,
                         input bit dw = 0, input int dwa = 0, input logic [31:0] dwd = 0);
        exp_t e;
        bit   imm_f, reg_f;
        int   amt;
        imm_f = (ins[7:0] == 8'h77) && (ins[22:21] == 2'd0);
        reg_f = (ins[7:0] == 8'h17) && (ins[23:21] == 3'd4);
        amt   = imm_f ? int'(ins[27:23]) : int'(mdl[ins[27:24]][4:0]);
        e.dst = ins[31:28];
        e.tag = tag;
        e.ill = !(imm_f || reg_f);
        e.val = e.ill ? mdl[e.dst] : ref_x(mdl[ins[11:8]], mdl[ins[15:12]], amt);
        if (dw) mdl[dwa] = dwd;
        if (!e.ill) mdl[e.dst] = e.val;
        else e.val = mdl[e.dst];
        sbq.push_back(e);
        @(negedge clk);
        instr = ins; instr_valid = 1'b1;
        dbg_we = dw; dbg_waddr = 4'(dwa); dbg_wdata = dwd;
        @(negedge clk);
        instr_valid = 1'b0; dbg_we = 1'b0;
    endtask

    // Monitor: on each pulse pop the expected item and compare.
    always @(negedge clk) begin
        if (rst_n && (done_o || illegal_o)) begin
            exp_t e;
            if (sbq.size() == 0) begin
                chk(0, "R8 unexpected pulse", {30'b0, done_o, illegal_o}, 0);
            end else begin
                e = sbq.pop_front();
                chk(illegal_o == e.ill && done_o == !e.ill, {e.tag, " flags"},
                    {30'b0, done_o, illegal_o}, {30'b0, !e.ill, e.ill});
                dbg_raddr = e.dst;
                #0.5;
                chk(dbg_rdata == e.val, {e.tag, " value"}, dbg_rdata, e.val);
            end
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state of every register and both flags
        for (int i = 0; i < 16; i++) begin
            dbg_raddr = 4'(i); #0.5;
            chk(dbg_rdata == 0, "R1 reg clear", dbg_rdata, 0);
        end
        chk(!done_o && !illegal_o, "R1 flags", {30'b0, done_o, illegal_o}, 0);
        @(negedge clk); rst_n = 1'b1;
        // R9: preload through the debug port
        for (int i = 0; i < 16; i++) begin
            mdl[i] = (32'(i) * 32'h9E3779B9) ^ 32'hC3A5_5A3C;
            dbg_we = 1'b1; dbg_waddr = 4'(i); dbg_wdata = mdl[i];
            @(negedge clk);
        end
        dbg_we = 1'b0;
        mdl[9]  = 32'hFFFF_FFE7;   // amount 7 with upper bits set
        mdl[10] = 32'h0000_0020;   // amount 0, bit 5 set
        dbg_we = 1'b1; dbg_waddr = 4'd9;  dbg_wdata = mdl[9];  @(negedge clk);
        dbg_waddr = 4'd10; dbg_wdata = mdl[10]; @(negedge clk);
        dbg_we = 1'b0;
        // R10: combinational read after preload
        dbg_raddr = 4'd5; #0.5;
        chk(dbg_rdata == mdl[5], "R10 dbg read", dbg_rdata, mdl[5]);
        // R8: idle cycles raise no pulse
        @(negedge clk);
        chk(!done_o && !illegal_o, "R8 idle", {30'b0, done_o, illegal_o}, 0);

        issue(enc_imm(1, 5, 3, 11, 0), "R2 imm 11");
        issue(enc_imm(2, 4, 6, 1, 0),  "R2 imm 1");
        issue(enc_imm(3, 7, 8, 31, 0), "R2 imm 31");
        issue(enc_imm(4, 2, 11, 0, 0), "R5 imm 0");
        issue(enc_reg(5, 12, 13, 9, 0), "R3 reg amt 7 upper set");
        issue(enc_reg(6, 14, 15, 10, 0), "R3 R5 reg amt 0 bit5 set");
        issue(enc_imm(7, 13, 13, 9, 0), "R4 same src imm");
        issue(enc_reg(8, 12, 12, 9, 0), "R4 same src reg");
        issue(enc_imm(11, 1, 2, 17, 5'h1F), "R6 junk imm");
        issue(enc_reg(12, 3, 4, 9, 5'h15), "R6 junk reg");
        issue(enc_imm(3, 3, 3, 5, 0), "R11 dst is src");
        issue(enc_imm(13, 0, 1, 3, 0), "R9 collide", 1, 13, 32'hDEAD_BEEF);
        issue(enc_imm(14, 0, 1, 4, 0), "R9 split", 1, 15, 32'h1234_5678);
        issue({4'd1, 5'd3, 2'b01, 5'd0, 4'd2, 4'd3, 8'h77}, "R7 imm sub bad");
        issue({4'd2, 4'd9, 3'b000, 5'd0, 4'd2, 4'd3, 8'h17}, "R7 reg sub bad");
        issue({4'd3, 5'd3, 2'b00, 5'd0, 4'd2, 4'd3, 8'h55}, "R7 opc bad");
        repeat (3) @(negedge clk);
        dbg_raddr = 4'd15; #0.5;
        chk(dbg_rdata == mdl[15], "R9 split dbg", dbg_rdata, mdl[15]);
        chk(sbq.size() == 0, "R8 queue drained", 32'(sbq.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule